// File: doc/BRIEF.md
# Single-channel memory-to-peripheral byte mover

This block is one DMA channel that copies a programmed number of bytes from memory to one fixed peripheral address. Software sets the source address, the peripheral address and the byte count, picks which interrupts it wants, and then sets the activate bit as its final step. After that, each request from the peripheral moves exactly one byte. The engine reads one byte from memory over a request/valid handshake. It then writes that byte to the peripheral with a one-cycle strobe, advances the source address by one and takes one off the remaining count.

Two status flags mark the progress of a transfer. The half flag is set when the remaining count first reaches half of the programmed count, rounded down. The full flag is set when the remaining count reaches zero, and at that point the activate bit clears itself. Software clears either flag by writing 1 to its bit in a separate clear register. Each interrupt line is its flag ANDed with its enable bit.

Top module: `dma_m2p_channel`

## Requirements
- R1: After reset every register reads 0 and per_wr, mrd_req, irq_half and irq_full are low.
- R2: The register offsets are 0 source, 1 destination, 2 count, 3 control (bit0 activate, bit1 half enable, bit2 full enable), 4 status (bit0 half, bit1 full) and 5 flag clear. Writing control with bit0=1 starts the channel only when the count is nonzero. When the count is 0 the write does not start it, and control bit0 still reads 0.
- R3: While the channel is active, each high per_req produces one memory read on mrd_addr. mrd_req stays high until mrd_valid. In a later cycle comes a one-cycle per_wr that carries the byte returned in mrd_data and has per_addr equal to the destination register.
- R4: The source register advances by one after every byte, so once the transfer completes it reads the start address plus the count. The destination never changes during a transfer.
- R5: The count register drops by one at each per_wr and reads 0 after the transfer completes.
- R6: Status bit0 (half) is set in the cycle after write number N - floor(N/2), where N is the programmed count.
- R7: Status bit1 (full) is set in the cycle after write number N, and control bit0 reads 0 from that cycle on.
- R8: While the channel is inactive, per_req is ignored: no mrd_req and no per_wr.
- R9: While the channel is active, writes to source, destination, count and control are ignored.
- R10: Writing 1 to bit0 or bit1 of the flag clear register clears the half or the full flag. A 0 bit leaves its flag unchanged.
- R11: irq_half equals the half flag AND control bit1, and irq_full equals the full flag AND control bit2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| per_req | input | 1 | Peripheral ready-for-data request |
| per_wr | output | 1 | Peripheral write strobe |
| per_addr | output | 32 | Peripheral destination address |
| per_data | output | 8 | Peripheral write byte |
| mrd_req | output | 1 | Memory read request, held until valid |
| mrd_addr | output | 32 | Memory read address |
| mrd_valid | input | 1 | Memory read data valid |
| mrd_data | input | 8 | Memory read byte |
| irq_half | output | 1 | Half-transfer interrupt |
| irq_full | output | 1 | Full-transfer interrupt |

## Verification
A wrong source address shows up at the very next per_wr as the wrong byte. A count that is off by one moves the half or full event by one write, which is visible on the interrupt lines one cycle after that strobe. A channel that should be idle but still reacts to requests, or that fails to clear its activate bit, appears as extra memory reads and peripheral strobes within a few cycles of per_req going high. Writes that should be ignored during a transfer would alter the bytes, the destination address or the final readbacks.

// File: rtl/dma_m2p_pkg.sv
package dma_m2p_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } xfer_state_e;

    localparam logic [2:0] OFS_SRC  = 3'd0;
    localparam logic [2:0] OFS_DST  = 3'd1;
    localparam logic [2:0] OFS_CNT  = 3'd2;
    localparam logic [2:0] OFS_CTRL = 3'd3;
    localparam logic [2:0] OFS_STAT = 3'd4;
    localparam logic [2:0] OFS_FCLR = 3'd5;

    localparam int CTRL_ACT = 0;
    localparam int CTRL_IEH = 1;
    localparam int CTRL_IEF = 2;
    localparam int STAT_HALF = 0;
    localparam int STAT_FULL = 1;

endpackage

// File: rtl/dma_m2p_regs.sv
module dma_m2p_regs
    import dma_m2p_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              busy_i,
    input  logic              strobe_i,
    input  logic              half_i,
    input  logic              done_i,
    output logic              start_o,
    output logic [ADDR_W-1:0] src_o,
    output logic [ADDR_W-1:0] dst_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              irq_half_o,
    output logic              irq_full_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
        logic              ieh;
        logic              ief;
        logic              fh;
        logic              ff;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  cfg_wr;

    always_comb begin
        regs_d  = regs_q;
        cfg_wr  = reg_we && !busy_i;
        start_o = cfg_wr && (reg_addr == OFS_CTRL) && reg_wdata[CTRL_ACT]
                  && (regs_q.cnt != '0);
        if (cfg_wr) begin
            case (reg_addr)
                OFS_SRC:  regs_d.src = reg_wdata[ADDR_W-1:0];
                OFS_DST:  regs_d.dst = reg_wdata[ADDR_W-1:0];
                OFS_CNT:  regs_d.cnt = reg_wdata[CNT_W-1:0];
                OFS_CTRL: begin
                    regs_d.ieh = reg_wdata[CTRL_IEH];
                    regs_d.ief = reg_wdata[CTRL_IEF];
                end
                default: ;
            endcase
        end
        if (strobe_i) begin
            regs_d.src = regs_q.src + ADDR_W'(1);
            regs_d.cnt = regs_q.cnt - CNT_W'(1);
        end
        if (reg_we && (reg_addr == OFS_FCLR)) begin
            if (reg_wdata[STAT_HALF]) regs_d.fh = 1'b0;
            if (reg_wdata[STAT_FULL]) regs_d.ff = 1'b0;
        end
        if (half_i) regs_d.fh = 1'b1;
        if (done_i) regs_d.ff = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_SRC:  reg_rdata[ADDR_W-1:0] = regs_q.src;
            OFS_DST:  reg_rdata[ADDR_W-1:0] = regs_q.dst;
            OFS_CNT:  reg_rdata[CNT_W-1:0]  = regs_q.cnt;
            OFS_CTRL: begin
                reg_rdata[CTRL_ACT] = busy_i;
                reg_rdata[CTRL_IEH] = regs_q.ieh;
                reg_rdata[CTRL_IEF] = regs_q.ief;
            end
            OFS_STAT: begin
                reg_rdata[STAT_HALF] = regs_q.fh;
                reg_rdata[STAT_FULL] = regs_q.ff;
            end
            default: ;
        endcase
    end

    assign src_o      = regs_q.src;
    assign dst_o      = regs_q.dst;
    assign cnt_o      = regs_q.cnt;
    assign irq_half_o = regs_q.fh && regs_q.ieh;
    assign irq_full_o = regs_q.ff && regs_q.ief;

    assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> (regs_q.cnt == $past(regs_q.cnt) - CNT_W'(1)));
    assert_src_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> (regs_q.src == $past(regs_q.src) + ADDR_W'(1)));
    assert_dst_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(regs_q.dst));
    assert_full_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> regs_q.ff);
    assert_half_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        half_i |=> regs_q.fh);

endmodule

// File: rtl/dma_m2p_xfer.sv
module dma_m2p_xfer
    import dma_m2p_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              per_req_i,
    input  logic              mrd_valid_i,
    input  logic [DATA_W-1:0] mrd_data_i,
    output logic              busy_o,
    output logic              mrd_req_o,
    output logic              strobe_o,
    output logic [DATA_W-1:0] per_data_o,
    output logic              half_o,
    output logic              done_o
);

    typedef struct packed {
        xfer_state_e       st;
        logic              busy;
        logic [CNT_W-1:0]  half_mark;
        logic [DATA_W-1:0] data;
    } xfer_t;

    xfer_t xs_d, xs_q;

    always_comb begin
        xs_d   = xs_q;
        half_o = 1'b0;
        done_o = 1'b0;
        case (xs_q.st)
            ST_IDLE: begin
                if (xs_q.busy && per_req_i) xs_d.st = ST_READ;
            end
            ST_READ: begin
                if (mrd_valid_i) begin
                    xs_d.data = mrd_data_i;
                    xs_d.st   = ST_WRITE;
                end
            end
            ST_WRITE: begin
                xs_d.st = ST_IDLE;
                half_o  = ((count_i - CNT_W'(1)) == xs_q.half_mark);
                done_o  = (count_i == CNT_W'(1));
                if (done_o) xs_d.busy = 1'b0;
            end
            default: xs_d.st = ST_IDLE;
        endcase
        if (start_i) begin
            xs_d.busy      = 1'b1;
            xs_d.half_mark = count_i >> 1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) xs_q <= '{st: ST_IDLE, busy: 1'b0, half_mark: '0, data: '0};
        else        xs_q <= xs_d;
    end

    assign busy_o     = xs_q.busy;
    assign mrd_req_o  = (xs_q.st == ST_READ);
    assign strobe_o   = (xs_q.st == ST_WRITE);
    assign per_data_o = xs_q.data;

    assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mrd_req_o && !mrd_valid_i) |=> mrd_req_o);
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !xs_q.busy |-> (!mrd_req_o && !strobe_o));
    assert_self_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xs_q.busy |-> !start_i);
    assert_strobe_after_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> $past(mrd_valid_i));

endmodule

// File: rtl/dma_m2p_channel.sv
module dma_m2p_channel
    import dma_m2p_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              per_req,
    output logic              per_wr,
    output logic [ADDR_W-1:0] per_addr,
    output logic [DATA_W-1:0] per_data,
    output logic              mrd_req,
    output logic [ADDR_W-1:0] mrd_addr,
    input  logic              mrd_valid,
    input  logic [DATA_W-1:0] mrd_data,
    output logic              irq_half,
    output logic              irq_full
);

    logic             busy, start, half_ev, done_ev;
    logic [CNT_W-1:0] cnt;

    dma_m2p_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy_i     (busy),
        .strobe_i   (per_wr),
        .half_i     (half_ev),
        .done_i     (done_ev),
        .start_o    (start),
        .src_o      (mrd_addr),
        .dst_o      (per_addr),
        .cnt_o      (cnt),
        .irq_half_o (irq_half),
        .irq_full_o (irq_full)
    );

    dma_m2p_xfer #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_xfer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .count_i     (cnt),
        .per_req_i   (per_req),
        .mrd_valid_i (mrd_valid),
        .mrd_data_i  (mrd_data),
        .busy_o      (busy),
        .mrd_req_o   (mrd_req),
        .strobe_o    (per_wr),
        .per_data_o  (per_data),
        .half_o      (half_ev),
        .done_o      (done_ev)
    );

    assert_wr_needs_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
        per_wr |-> busy);

endmodule

// File: tb/tb_dma_m2p_channel.sv
module tb_dma_m2p_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        per_req = 1'b0;
    logic        per_wr;
    logic [31:0] per_addr;
    logic [7:0]  per_data;
    logic        mrd_req;
    logic [31:0] mrd_addr;
    logic        mrd_valid = 1'b0;
    logic [7:0]  mrd_data = 8'd0;
    logic        irq_half, irq_full;

    always #10 clk = ~clk;

    dma_m2p_channel dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_req(per_req),
        .per_wr(per_wr), .per_addr(per_addr), .per_data(per_data),
        .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_valid(mrd_valid),
        .mrd_data(mrd_data), .irq_half(irq_half), .irq_full(irq_full)
    );

    int total = 0;
    int bad   = 0;

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    // memory model: variable latency, one-cycle valid
    int lat = 0;
    int lat_cnt = 0;
    int mreq_cycles = 0;
    always @(posedge clk) begin
        if (mrd_req) mreq_cycles <= mreq_cycles + 1;
        if (mrd_valid) mrd_valid <= 1'b0;
        else if (mrd_req) begin
            if (lat_cnt >= lat) begin
                mrd_valid <= 1'b1;
                mrd_data  <= mem_byte(mrd_addr);
                lat_cnt   <= 0;
            end else lat_cnt <= lat_cnt + 1;
        end
    end

    // peripheral model and write monitor
    logic        pen = 1'b0;
    int          wcnt = 0;
    int          wbase = 0;
    int          bad_wr = 0;
    logic [31:0] exp_src = 32'd0;
    logic [31:0] exp_dst = 32'd0;
    always @(posedge clk) begin
        if (per_wr) begin
            if (per_data !== mem_byte(exp_src + 32'(wcnt - wbase)) || per_addr !== exp_dst)
                bad_wr <= bad_wr + 1;
            wcnt <= wcnt + 1;
            per_req <= 1'b0;
        end else if (pen) per_req <= 1'b1;
        else per_req <= 1'b0;
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    typedef struct packed {
        logic [31:0] src;
        logic [15:0] cnt;
        logic [3:0]  lat;
        logic        ieh;
        logic        ief;
    } vec_t;

    localparam vec_t VECS [0:3] = '{
        '{src: 32'h0000_0100, cnt: 16'd8,  lat: 4'd0, ieh: 1'b1, ief: 1'b1},
        '{src: 32'h0000_02FE, cnt: 16'd5,  lat: 4'd3, ieh: 1'b1, ief: 1'b1},
        '{src: 32'h0000_0040, cnt: 16'd1,  lat: 4'd1, ieh: 1'b1, ief: 1'b1},
        '{src: 32'h0000_1000, cnt: 16'd16, lat: 4'd7, ieh: 1'b0, ief: 1'b1}
    };

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic        half_seen, full_seen;
        int          half_at, full_at, bw0, wait_n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), r);
            chk(r == 32'd0, "R1 register reset", r, 0);
        end
        chk({per_wr, mrd_req, irq_half, irq_full} == 4'd0, "R1 outputs reset",
            {per_wr, mrd_req, irq_half, irq_full}, 0);

        // R8 requests ignored while inactive
        pen = 1'b1;
        repeat (20) @(negedge clk);
        chk(wcnt == 0 && mreq_cycles == 0, "R8 inactive ignores requests",
            32'(wcnt + mreq_cycles), 0);

        // R2 activation with count 0 is refused
        wr(3'd1, 32'h55);
        wr(3'd3, 32'h7);
        repeat (10) @(negedge clk);
        rd(3'd3, r);
        chk(r[0] == 1'b0, "R2 zero-count activate refused", r, 32'h6);
        chk(wcnt == 0 && mreq_cycles == 0, "R2 zero-count moves nothing",
            32'(wcnt + mreq_cycles), 0);
        pen = 1'b0;
        repeat (2) @(negedge clk);

        // table-driven transfers
        for (int v = 0; v < 4; v++) begin
            lat = int'(VECS[v].lat);
            exp_src = VECS[v].src;
            exp_dst = 32'h4000_0010 + 32'(v);
            wbase = wcnt;
            bw0 = bad_wr;
            half_seen = 1'b0; full_seen = 1'b0; half_at = -1; full_at = -1;
            wr(3'd0, VECS[v].src);
            wr(3'd1, exp_dst);
            wr(3'd2, 32'(VECS[v].cnt));
            pen = 1'b1;
            wr(3'd3, {29'd0, VECS[v].ief, VECS[v].ieh, 1'b1});
            wait_n = 0;
            do begin
                if (irq_half && !half_seen) begin half_seen = 1'b1; half_at = wcnt - wbase; end
                if (irq_full && !full_seen) begin full_seen = 1'b1; full_at = wcnt - wbase; end
                rd(3'd3, r);
                if (r[0] == 1'b0) break;
                @(negedge clk);
                wait_n++;
            end while (wait_n < 5000);
            if (irq_half && !half_seen) begin half_seen = 1'b1; half_at = wcnt - wbase; end
            if (irq_full && !full_seen) begin full_seen = 1'b1; full_at = wcnt - wbase; end
            pen = 1'b0;
            chk(wcnt - wbase == int'(VECS[v].cnt), "R3 byte count", 32'(wcnt - wbase),
                32'(VECS[v].cnt));
            chk(bad_wr == bw0, "R3 bytes and destination", 32'(bad_wr - bw0), 0);
            rd(3'd0, r);
            chk(r == VECS[v].src + 32'(VECS[v].cnt), "R4 source advanced", r,
                VECS[v].src + 32'(VECS[v].cnt));
            rd(3'd2, r);
            chk(r == 32'd0, "R5 count at end", r, 0);
            if (VECS[v].ieh)
                chk(half_at == int'(VECS[v].cnt - (VECS[v].cnt >> 1)), "R6 half point",
                    32'(half_at), 32'(VECS[v].cnt - (VECS[v].cnt >> 1)));
            else
                chk(!half_seen, "R11 half irq masked", 32'(half_seen), 0);
            chk(full_at == int'(VECS[v].cnt), "R7 full point", 32'(full_at),
                32'(VECS[v].cnt));
            rd(3'd4, r);
            chk(r == 32'h3, "R6 R7 status flags", r, 3);
            wr(3'd5, 32'h1);
            rd(3'd4, r);
            chk(r == 32'h2, "R10 clear half only", r, 2);
            chk(irq_half == 1'b0 && irq_full == VECS[v].ief, "R11 irq follows flags",
                {irq_half, irq_full}, {1'b0, VECS[v].ief});
            wr(3'd5, 32'h2);
            rd(3'd4, r);
            chk(r == 32'h0 && !irq_full, "R10 clear full", r, 0);
            repeat (2) @(negedge clk);
        end

        // R9 config writes ignored while active; R5 mid-transfer count
        lat = 5;
        exp_src = 32'h500;
        exp_dst = 32'h77;
        wbase = wcnt;
        bw0 = bad_wr;
        wr(3'd0, 32'h500);
        wr(3'd1, 32'h77);
        wr(3'd2, 32'd16);
        pen = 1'b1;
        wr(3'd3, 32'h1);
        wait_n = 0;
        while (wcnt - wbase < 3 && wait_n < 5000) begin @(negedge clk); wait_n++; end
        rd(3'd2, r);
        chk(r == 32'd13, "R5 count mid-transfer", r, 13);
        wr(3'd0, 32'hDEAD);
        wr(3'd1, 32'hBEEF);
        wr(3'd2, 32'd2);
        wr(3'd3, 32'h6);
        wait_n = 0;
        do begin
            rd(3'd3, r);
            if (r[0] == 1'b0) break;
            @(negedge clk);
            wait_n++;
        end while (wait_n < 5000);
        pen = 1'b0;
        chk(wcnt - wbase == 16, "R9 count write ignored", 32'(wcnt - wbase), 16);
        chk(bad_wr == bw0, "R9 source and destination writes ignored",
            32'(bad_wr - bw0), 0);
        rd(3'd0, r);
        chk(r == 32'h510, "R9 R4 source after transfer", r, 32'h510);
        rd(3'd3, r);
        chk(r == 32'h0, "R9 R7 control unchanged and inactive", r, 0);
        rd(3'd4, r);
        chk(r == 32'h3 && !irq_half && !irq_full, "R11 flags set, irqs disabled", r, 3);

        // R8 after completion, requests ignored again
        bw0 = wcnt;
        pen = 1'b1;
        repeat (20) @(negedge clk);
        pen = 1'b0;
        chk(wcnt == bw0, "R8 ignored after completion", 32'(wcnt - bw0), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule